// File: doc/BRIEF.md
# DPLL Operating Mode Controller

This block decides which operating mode a digital phase-locked synchronizer runs in and which frequency control word feeds its oscillator. It has four states: `MODE_NORMAL` (tracking the reference), `MODE_AUTO_HOLD` (holdover entered because the reference went bad), `MODE_HOLD` (holdover requested on the mode pins) and `MODE_FREE` (free-running on the master oscillator). Two mode-select pins are re-timed by a two-flop synchronizer and decoded into a request. A reference-invalid flag alone moves the block between Normal and Auto-Holdover. The block also decides whether phase-step (TIE) correction stays on after each transition.

Named transitions: `T_LOSS` (Normal to Auto-Holdover, reference invalid), `T_RECOVER` (Auto-Holdover to Normal, reference valid), `T_REQ_HOLD` (any state to Holdover, pins 01), `T_REQ_FREE` (any state to Freerun, pins 10) and `T_RESUME` (Holdover or Freerun to Normal or Auto-Holdover, pins 00 or 11, with the target chosen by the flag). Reset enters `MODE_FREE`.

While in Normal and locked, each pulse of an external 30 ms tick stores the live control word. The stores go alternately into two slots. In either holdover state the block drives the older of the two slots, so the word in use is 30 to 60 ms old. It drives the nominal centre word instead until both slots have been written since reset, and always drives the nominal word in Freerun.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: After reset the block is in Freerun: `st_freerun`=1, the other status outputs are 0, `tie_active`=0 and `fcw_out`=NOMINAL.
- R2: The mode pins are decoded as 00=Normal, 01=Holdover, 10=Freerun and 11=Normal. A pin change sampled at a rising edge changes the state at the third rising edge counted from that one, never sooner.
- R3: With a Normal request on the pins, `ref_invalid`=1 in Normal moves the block to Auto-Holdover at the next edge, and `ref_invalid`=0 in Auto-Holdover moves it back to Normal at the next edge.
- R4: In Holdover and in Freerun, `ref_invalid` has no effect on the state or on `fcw_out`.
- R5: Exactly one of `st_normal`, `st_auto_hold`, `st_holdover` and `st_freerun` is high, and it matches the current state.
- R6: `fast_lock` equals `fast_lock_req` while in Normal and is 0 in every other state.
- R7: Every state transition clears `tie_active`, except a transition from Holdover or Auto-Holdover into Normal.
- R8: On a transition from Holdover or Auto-Holdover into Normal, `tie_active` takes the value `tie_en_in` has at that edge, and keeps it until the next transition.
- R9: In Normal with `locked`=1, each edge with `tick_30ms`=1 stores `fcw_in` into a slot. The first store after reset goes to slot A, and the following stores alternate B, A, B and so on.
- R10: In either holdover state, `fcw_out` is the slot written earlier of the two. It is NOMINAL until both slots have been written since reset.
- R11: `fcw_out` equals `fcw_in` in Normal and NOMINAL in Freerun.
- R12: No slot is written while `locked`=0 or while the state is not Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Asynchronous mode-select pins |
| ref_invalid | input | 1 | Reference out of capture range |
| locked | input | 1 | Loop reports phase lock |
| fast_lock_req | input | 1 | Fast-lock submode request |
| tie_en_in | input | 1 | TIE enable used on return to Normal |
| tick_30ms | input | 1 | One-cycle pulse every 30 ms |
| fcw_in | input | FCW_W | Live frequency control word from the loop |
| fcw_out | output | FCW_W | Word to drive the oscillator |
| st_normal | output | 1 | In Normal |
| st_auto_hold | output | 1 | In Auto-Holdover |
| st_holdover | output | 1 | In manual Holdover |
| st_freerun | output | 1 | In Freerun |
| fast_lock | output | 1 | Fast-lock submode active |
| tie_active | output | 1 | TIE correction enabled |

## Verification
Results fall due at different times. A change on `ref_invalid` shows on the status outputs, `tie_active` and the holdover word one edge later. A mode-pin change lands three edges after the pins are first sampled. `fast_lock` and the Normal pass-through of `fcw_in` follow their inputs within the same cycle. The bench drives inputs 1 ns after a rising edge and samples 1 ns after the edge on which a result is due. For pin changes it also samples after the second edge, to confirm that the state has not moved early.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL    = 2'd0,
        MODE_AUTO_HOLD = 2'd1,
        MODE_HOLD      = 2'd2,
        MODE_FREE      = 2'd3
    } op_mode_t;

    typedef enum logic [1:0] {
        REQ_NORMAL = 2'd0,
        REQ_HOLD   = 2'd1,
        REQ_FREE   = 2'd2
    } mode_req_t;

endpackage

// File: rtl/mode_pin_sync.sv
module mode_pin_sync
    import dpll_mode_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pins_async,
    output mode_req_t  req
);

    logic [1:0] stage_q [SYNC_STAGES];

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= 2'b10;
                    else        stage_q[g] <= pins_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= 2'b10;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    always_comb begin
        unique case (stage_q[SYNC_STAGES-1])
            2'b00:   req = REQ_NORMAL;
            2'b01:   req = REQ_HOLD;
            2'b10:   req = REQ_FREE;
            default: req = REQ_NORMAL;
        endcase
    end

endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import dpll_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  mode_req_t req,
    input  logic      ref_invalid,
    input  logic      tie_en_in,
    output op_mode_t  state_q,
    output logic      tie_q
);

    op_mode_t state_d;
    logic     moving;
    logic     into_normal_from_hold;

    always_comb begin
        state_d = state_q;
        unique case (req)
            REQ_HOLD: state_d = MODE_HOLD;
            REQ_FREE: state_d = MODE_FREE;
            default: begin
                unique case (state_q)
                    MODE_NORMAL:    if (ref_invalid)  state_d = MODE_AUTO_HOLD;
                    MODE_AUTO_HOLD: if (!ref_invalid) state_d = MODE_NORMAL;
                    MODE_HOLD,
                    MODE_FREE:      state_d = ref_invalid ? MODE_AUTO_HOLD : MODE_NORMAL;
                    default:        state_d = MODE_FREE;
                endcase
            end
        endcase
    end

    assign moving = (state_d != state_q);
    assign into_normal_from_hold = (state_d == MODE_NORMAL) &&
        ((state_q == MODE_HOLD) || (state_q == MODE_AUTO_HOLD));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     tie_q <= 1'b0;
        else if (into_normal_from_hold) tie_q <= tie_en_in;
        else if (moving)                tie_q <= 1'b0;
    end

    p_loss_enter_auto_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_NORMAL && req == REQ_NORMAL && ref_invalid) |=> (state_q == MODE_AUTO_HOLD));

    p_auto_ignores_hold_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_HOLD && req == REQ_HOLD) |=> (state_q == MODE_HOLD));

    p_tie_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (moving && !into_normal_from_hold) |=> !tie_q);

    p_tie_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        into_normal_from_hold |=> (tie_q == $past(tie_en_in)));

endmodule

// File: rtl/holdover_store.sv
module holdover_store #(
    parameter int          FCW_W   = 16,
    parameter logic [FCW_W-1:0] NOMINAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ok,
    input  logic             tick,
    input  logic [FCW_W-1:0] fcw_in,
    output logic [FCW_W-1:0] hold_word
);

    localparam int SLOTS = 2;

    logic [FCW_W-1:0] slot_q  [SLOTS];
    logic [SLOTS-1:0] valid_q;
    logic             wr_sel_q;
    logic             do_write;

    assign do_write = wr_ok && tick;

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    slot_q[g]  <= NOMINAL;
                    valid_q[g] <= 1'b0;
                end else if (do_write && (wr_sel_q == g[0])) begin
                    slot_q[g]  <= fcw_in;
                    valid_q[g] <= 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        wr_sel_q <= 1'b0;
        else if (do_write) wr_sel_q <= ~wr_sel_q;
    end

    // The slot due to be overwritten next is the one written earlier.
    assign hold_word = (&valid_q) ? slot_q[wr_sel_q] : NOMINAL;

    p_alternate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        do_write |=> (wr_sel_q != $past(wr_sel_q)));

    p_no_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !do_write |=> ($stable(slot_q[0]) && $stable(slot_q[1]) && $stable(wr_sel_q)));

endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
    import dpll_mode_pkg::*;
#(
    parameter int               FCW_W   = 16,
    parameter logic [FCW_W-1:0] NOMINAL = 16'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             ref_invalid,
    input  logic             locked,
    input  logic             fast_lock_req,
    input  logic             tie_en_in,
    input  logic             tick_30ms,
    input  logic [FCW_W-1:0] fcw_in,
    output logic [FCW_W-1:0] fcw_out,
    output logic             st_normal,
    output logic             st_auto_hold,
    output logic             st_holdover,
    output logic             st_freerun,
    output logic             fast_lock,
    output logic             tie_active
);

    mode_req_t        req;
    op_mode_t         state;
    logic [FCW_W-1:0] hold_word;

    mode_pin_sync #(.SYNC_STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_async(mode_sel),
        .req       (req)
    );

    mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .ref_invalid(ref_invalid),
        .tie_en_in  (tie_en_in),
        .state_q    (state),
        .tie_q      (tie_active)
    );

    holdover_store #(.FCW_W(FCW_W), .NOMINAL(NOMINAL)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ok    (st_normal && locked),
        .tick     (tick_30ms),
        .fcw_in   (fcw_in),
        .hold_word(hold_word)
    );

    always_comb begin
        st_normal    = 1'b0;
        st_auto_hold = 1'b0;
        st_holdover  = 1'b0;
        st_freerun   = 1'b0;
        fcw_out      = NOMINAL;
        unique case (state)
            MODE_NORMAL:    begin st_normal    = 1'b1; fcw_out = fcw_in;    end
            MODE_AUTO_HOLD: begin st_auto_hold = 1'b1; fcw_out = hold_word; end
            MODE_HOLD:      begin st_holdover  = 1'b1; fcw_out = hold_word; end
            MODE_FREE:      begin st_freerun   = 1'b1; fcw_out = NOMINAL;   end
            default:        begin st_freerun   = 1'b1; fcw_out = NOMINAL;   end
        endcase
        fast_lock = st_normal && fast_lock_req;
    end

    p_status_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({st_normal, st_auto_hold, st_holdover, st_freerun}));

    p_fastlock_only_normal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fast_lock |-> st_normal);

    p_freerun_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
        st_freerun |-> (fcw_out == NOMINAL));

endmodule

// File: tb/test_dpll_mode_ctrl.sv
module test_dpll_mode_ctrl;

    localparam int          W   = 16;
    localparam logic [W-1:0] NOM = 16'h8000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode_sel = 2'b10;
    logic         ref_invalid = 1'b0;
    logic         locked = 1'b0;
    logic         fast_lock_req = 1'b0;
    logic         tie_en_in = 1'b0;
    logic         tick_30ms = 1'b0;
    logic [W-1:0] fcw_in = '0;
    logic [W-1:0] fcw_out;
    logic st_normal, st_auto_hold, st_holdover, st_freerun, fast_lock, tie_active;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    dpll_mode_ctrl #(.FCW_W(W), .NOMINAL(NOM)) i_dpll_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ref_invalid(ref_invalid),
        .locked(locked), .fast_lock_req(fast_lock_req), .tie_en_in(tie_en_in),
        .tick_30ms(tick_30ms), .fcw_in(fcw_in), .fcw_out(fcw_out),
        .st_normal(st_normal), .st_auto_hold(st_auto_hold), .st_holdover(st_holdover),
        .st_freerun(st_freerun), .fast_lock(fast_lock), .tie_active(tie_active)
    );

    // status vector order: {normal, auto, hold, free}
    function automatic logic [3:0] stat();
        return {st_normal, st_auto_hold, st_holdover, st_freerun};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic tick_word(input logic [W-1:0] v);
        fcw_in = v; tick_30ms = 1'b1;
        step(1);
        tick_30ms = 1'b0;
    endtask

    task automatic t_reset();
        chk(stat() == 4'b0001, "R1", stat(), 4'b0001);
        chk(tie_active == 1'b0, "R1", tie_active, 0);
        chk(fcw_out == NOM, "R1", fcw_out, NOM);
    endtask

    task automatic t_pins_to_normal();
        tie_en_in = 1'b1; fcw_in = 16'h1234;
        mode_sel = 2'b00;
        step(2);
        chk(stat() == 4'b0001, "R2 early", stat(), 4'b0001);
        step(1);
        chk(stat() == 4'b1000, "R2", stat(), 4'b1000);
        chk(tie_active == 1'b0, "R7 free->normal", tie_active, 0);
        chk(fcw_out == 16'h1234, "R11 normal pass", fcw_out, 16'h1234);
        fast_lock_req = 1'b1; #1;
        chk(fast_lock == 1'b1, "R6", fast_lock, 1);
    endtask

    task automatic t_store_and_auto();
        locked = 1'b1;
        tick_word(16'h1111);
        ref_invalid = 1'b1;
        step(1);
        chk(stat() == 4'b0100, "R3 loss", stat(), 4'b0100);
        chk(fcw_out == NOM, "R10 one slot", fcw_out, NOM);
        chk(fast_lock == 1'b0, "R6 auto", fast_lock, 0);
        tick_word(16'h5555);
        ref_invalid = 1'b0; tie_en_in = 1'b1;
        step(1);
        chk(stat() == 4'b1000, "R3 recover", stat(), 4'b1000);
        chk(tie_active == 1'b1, "R8 auto->normal", tie_active, 1);
        tick_word(16'h2222);
        tick_word(16'h3333);
        locked = 1'b0;
        tick_word(16'h4444);
        locked = 1'b1;
        ref_invalid = 1'b1;
        step(1);
        chk(stat() == 4'b0100, "R3 loss 2", stat(), 4'b0100);
        chk(fcw_out == 16'h2222, "R9 R10 R12 older slot", fcw_out, 16'h2222);
        chk(tie_active == 1'b0, "R7 normal->auto", tie_active, 0);
    endtask

    task automatic t_manual();
        mode_sel = 2'b01;
        step(3);
        chk(stat() == 4'b0010, "R2 hold", stat(), 4'b0010);
        ref_invalid = 1'b0;
        step(2);
        chk(stat() == 4'b0010, "R4 hold", stat(), 4'b0010);
        chk(fcw_out == 16'h2222, "R4 R10 hold word", fcw_out, 16'h2222);
        tie_en_in = 1'b0;
        mode_sel = 2'b00;
        step(3);
        chk(stat() == 4'b1000, "R2 resume", stat(), 4'b1000);
        chk(tie_active == 1'b0, "R8 follows 0", tie_active, 0);
        mode_sel = 2'b11;
        step(3);
        chk(stat() == 4'b1000, "R2 code 11", stat(), 4'b1000);
        ref_invalid = 1'b1;
        step(1);
        chk(stat() == 4'b0100, "R3 pins 11", stat(), 4'b0100);
        mode_sel = 2'b01; tie_en_in = 1'b1;
        step(3);
        mode_sel = 2'b00; ref_invalid = 1'b0;
        step(3);
        chk(tie_active == 1'b1, "R8 hold->normal", tie_active, 1);
        mode_sel = 2'b10;
        step(3);
        chk(stat() == 4'b0001, "R2 free", stat(), 4'b0001);
        chk(tie_active == 1'b0, "R7 normal->free", tie_active, 0);
        ref_invalid = 1'b1;
        step(2);
        chk(stat() == 4'b0001, "R4 free", stat(), 4'b0001);
        chk(fcw_out == NOM, "R11 free word", fcw_out, NOM);
        chk(fast_lock == 1'b0, "R6 free", fast_lock, 0);
        mode_sel = 2'b00;
        step(3);
        chk(stat() == 4'b0100, "R3 free->auto", stat(), 4'b0100);
        chk(fcw_out == 16'h2222, "R12 no writes outside normal", fcw_out, 16'h2222);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_pins_to_normal();
        t_store_and_auto();
        t_manual();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule